// File: doc/BRIEF.md
# Link-Register Subroutine Sequencer

This block holds the program counter of a small microsequencer and a bank of four link registers used for subroutine linkage. On each cycle in which `step_en` is high it takes one decoded control word: a plain advance, a taken jump, a call or a return. With the word come a destination link index, a source link index and a target address. From these it forms the next PC. PC values count instructions, so a plain advance adds one. The link indices are literal instruction fields, not operand values. A return saves its own link address into the destination register and jumps through the source register, so two routines can hand control back and forth.

The link registers are also visible through a small register-mapped port at word addresses `LR_BASE` to `LR_BASE+3`. A write through the port does not reach the live register. It is parked in a shadow copy, and it only goes live when the same register is later read through the port; that read returns the parked value. Control and port pins are plain single-cycle strobes. The block always accepts a step and a port access, so it applies no back-pressure.

A sticky error flag reports a call that reuses a link register whose previous call has not yet been returned through.

Top module: `lr_sequencer`

## Requirements
- R1: After reset, `pc` is 0, every link register reads 0, no port write is pending, and `ovf_err` is 0.
- R2: With `step_en` high and `step_op`=0 (advance), `pc` becomes `pc+1` modulo 2^PC_W on the next edge. With `step_en` low, `pc` does not change.
- R3: With `step_en` high and `step_op`=1 (jump), `pc` becomes `step_target` on the next edge.
- R4: With `step_en` high and `step_op`=2 (call), the link register named by `step_dst` receives `pc+1` and `pc` becomes `step_target`.
- R5: With `step_en` high and `step_op`=3 (return), `pc` becomes the live value of the link register named by `step_src` and the register named by `step_dst` receives `pc+1`. When both indices match, the jump uses the value held before the write.
- R6: Port address `LR_BASE+i` (default 0x868+i) selects link register i. `reg_hit` is high in a cycle with `reg_rd` or `reg_wr` and an address in that range. A write to an address outside the range changes nothing.
- R7: A port write is stored as pending and leaves the live register unchanged, so returns still jump to the old value. A later port read of that register returns the pending value and makes it live from the next edge. A port read with nothing pending returns the live value.
- R8: A call to a link register that has been set by a call and not yet consumed as a return source raises `ovf_err`. The call still writes the register, and `ovf_err` stays high until reset.
- R9: `reg_rdata` is 0 in any cycle without an in-range port read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_en | input | 1 | Apply the control word this cycle |
| step_op | input | 2 | 0 advance, 1 jump, 2 call, 3 return |
| step_dst | input | 2 | Link register written by call or return |
| step_src | input | 2 | Link register read by return |
| step_target | input | PC_W | Jump or call target |
| pc | output | PC_W | Current program counter |
| reg_addr | input | 16 | Register port word address |
| reg_wr | input | 1 | Register port write strobe |
| reg_rd | input | 1 | Register port read strobe |
| reg_wdata | input | PC_W | Register port write data |
| reg_rdata | output | PC_W | Register port read data (same cycle) |
| reg_hit | output | 1 | Access falls in the link-register window |
| ovf_err | output | 1 | Sticky link reuse error |

## Verification
The checker assumes that a port read and a port write are never strobed in the same cycle. It also assumes that `step_op` is a defined two-bit value whenever `step_en` is high. The bench drives port accesses one at a time through separate tasks, and it only raises `step_en` together with a known opcode. The checker does not model the sequencer writing the same link register in the cycle a port read retires a pending value. The directed scenarios keep those two events apart.

// File: rtl/lrs_pkg.sv
package lrs_pkg;
  typedef enum logic [1:0] {
    OP_SEQ  = 2'd0,
    OP_JUMP = 2'd1,
    OP_CALL = 2'd2,
    OP_RET  = 2'd3
  } step_op_e;
endpackage

// File: rtl/lrs_port_decode.sv
module lrs_port_decode #(
  parameter int          ADDR_W  = 16,
  parameter int          NUM_LR  = 4,
  parameter logic [15:0] LR_BASE = 16'h0868,
  localparam int         IDX_W   = $clog2(NUM_LR)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              in_window,
  output logic [IDX_W-1:0]  idx
);
  logic [ADDR_W-1:0] offset;

  always_comb begin
    offset    = addr - ADDR_W'(LR_BASE);
    in_window = (offset < ADDR_W'(NUM_LR));
    idx       = offset[IDX_W-1:0];
  end
endmodule

// File: rtl/lrs_pc_unit.sv
module lrs_pc_unit
  import lrs_pkg::*;
#(
  parameter int PC_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step_en,
  input  step_op_e        op,
  input  logic [PC_W-1:0] target,
  input  logic [PC_W-1:0] link_value,
  output logic [PC_W-1:0] pc_q,
  output logic [PC_W-1:0] pc_inc
);
  logic [PC_W-1:0] pc_next;

  assign pc_inc = pc_q + PC_W'(1);

  always_comb begin
    pc_next = pc_q;
    if (step_en) begin
      unique case (op)
        OP_SEQ:  pc_next = pc_inc;
        OP_JUMP: pc_next = target;
        OP_CALL: pc_next = target;
        OP_RET:  pc_next = link_value;
        default: pc_next = pc_inc;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_next;
  end
endmodule

// File: rtl/lrs_link_file.sv
module lrs_link_file #(
  parameter int  PC_W   = 12,
  parameter int  NUM_LR = 4,
  localparam int IDX_W  = $clog2(NUM_LR)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seq_we,
  input  logic [IDX_W-1:0] seq_widx,
  input  logic [PC_W-1:0]  seq_wdata,
  input  logic [IDX_W-1:0] seq_ridx,
  output logic [PC_W-1:0]  seq_rdata,
  input  logic             arm_set,
  input  logic [IDX_W-1:0] arm_idx,
  input  logic             arm_clr,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic             port_we,
  input  logic             port_re,
  input  logic [IDX_W-1:0] port_idx,
  input  logic [PC_W-1:0]  port_wdata,
  output logic [PC_W-1:0]  port_rdata,
  output logic             ovf_err
);
  logic [NUM_LR-1:0][PC_W-1:0] live_all;
  logic [NUM_LR-1:0][PC_W-1:0] shadow_all;
  logic [NUM_LR-1:0]           pend_all;
  logic [NUM_LR-1:0]           armed_all;
  logic                        ovf_q;

  for (genvar i = 0; i < NUM_LR; i++) begin : g_ent
    logic [PC_W-1:0] live_q;
    logic [PC_W-1:0] shadow_q;
    logic            pend_q;
    logic            armed_q;
    logic            seq_hit;
    logic            wr_hit;
    logic            rd_hit;

    assign seq_hit = seq_we  && (seq_widx == IDX_W'(i));
    assign wr_hit  = port_we && (port_idx == IDX_W'(i));
    assign rd_hit  = port_re && (port_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        live_q   <= '0;
        shadow_q <= '0;
        pend_q   <= 1'b0;
        armed_q  <= 1'b0;
      end else begin
        if (seq_hit)               live_q <= seq_wdata;
        else if (rd_hit && pend_q) live_q <= shadow_q;

        if (wr_hit) begin
          shadow_q <= port_wdata;
          pend_q   <= 1'b1;
        end else if (rd_hit) begin
          pend_q   <= 1'b0;
        end

        if (arm_set && arm_idx == IDX_W'(i))      armed_q <= 1'b1;
        else if (arm_clr && clr_idx == IDX_W'(i)) armed_q <= 1'b0;
      end
    end

    assign live_all[i]   = live_q;
    assign shadow_all[i] = shadow_q;
    assign pend_all[i]   = pend_q;
    assign armed_all[i]  = armed_q;
  end

  assign seq_rdata  = live_all[seq_ridx];
  assign port_rdata = pend_all[port_idx] ? shadow_all[port_idx]
                                         : live_all[port_idx];

  always_ff @(posedge clk) begin
    if (!rst_n)                             ovf_q <= 1'b0;
    else if (arm_set && armed_all[arm_idx]) ovf_q <= 1'b1;
  end

  assign ovf_err = ovf_q;
endmodule

// File: rtl/lr_sequencer.sv
module lr_sequencer
  import lrs_pkg::*;
#(
  parameter int          PC_W    = 12,
  parameter int          ADDR_W  = 16,
  parameter logic [15:0] LR_BASE = 16'h0868
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic [1:0]        step_op,
  input  logic [1:0]        step_dst,
  input  logic [1:0]        step_src,
  input  logic [PC_W-1:0]   step_target,
  output logic [PC_W-1:0]   pc,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [PC_W-1:0]   reg_wdata,
  output logic [PC_W-1:0]   reg_rdata,
  output logic              reg_hit,
  output logic              ovf_err
);
  localparam int NUM_LR = 4;
  localparam int IDX_W  = $clog2(NUM_LR);

  step_op_e        op;
  logic [PC_W-1:0] pc_inc;
  logic [PC_W-1:0] link_value;
  logic [PC_W-1:0] port_value;
  logic            in_window;
  logic [IDX_W-1:0] port_idx;
  logic            is_call;
  logic            is_ret;
  logic            port_we;
  logic            port_re;

  assign op      = step_op_e'(step_op);
  assign is_call = step_en && (op == OP_CALL);
  assign is_ret  = step_en && (op == OP_RET);
  assign port_we = reg_wr && in_window;
  assign port_re = reg_rd && in_window;

  lrs_port_decode #(
    .ADDR_W (ADDR_W),
    .NUM_LR (NUM_LR),
    .LR_BASE(LR_BASE)
  ) u_decode (
    .addr     (reg_addr),
    .in_window(in_window),
    .idx      (port_idx)
  );

  lrs_pc_unit #(.PC_W(PC_W)) u_pc (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_en   (step_en),
    .op        (op),
    .target    (step_target),
    .link_value(link_value),
    .pc_q      (pc),
    .pc_inc    (pc_inc)
  );

  lrs_link_file #(.PC_W(PC_W), .NUM_LR(NUM_LR)) u_links (
    .clk       (clk),
    .rst_n     (rst_n),
    .seq_we    (is_call || is_ret),
    .seq_widx  (step_dst),
    .seq_wdata (pc_inc),
    .seq_ridx  (step_src),
    .seq_rdata (link_value),
    .arm_set   (is_call),
    .arm_idx   (step_dst),
    .arm_clr   (is_ret),
    .clr_idx   (step_src),
    .port_we   (port_we),
    .port_re   (port_re),
    .port_idx  (port_idx),
    .port_wdata(reg_wdata),
    .port_rdata(port_value),
    .ovf_err   (ovf_err)
  );

  assign reg_hit   = (reg_wr || reg_rd) && in_window;
  assign reg_rdata = port_re ? port_value : '0;
endmodule

// File: rtl/lrs_checker.sv
module lrs_checker #(
  parameter int PC_W   = 12,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              step_en,
  input logic [1:0]        step_op,
  input logic [PC_W-1:0]   step_target,
  input logic [PC_W-1:0]   pc,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [PC_W-1:0]   reg_rdata,
  input logic              reg_hit,
  input logic              ovf_err
);
  AST_PORT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_rd)); // R7
  AST_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && step_op == 2'd0) |=> (pc == $past(pc) + PC_W'(1))); // R2
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(pc)); // R2
  AST_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && step_op == 2'd1) |=> (pc == $past(step_target))); // R3
  AST_CALL_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && step_op == 2'd2) |=> (pc == $past(step_target))); // R4
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> ovf_err); // R8
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rd && reg_hit) |-> (reg_rdata == '0)); // R9
  AST_HIT_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_hit |-> (reg_wr || reg_rd)); // R6
endmodule

bind lr_sequencer lrs_checker #(.PC_W(PC_W), .ADDR_W(ADDR_W)) i_lrs_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .step_en    (step_en),
  .step_op    (step_op),
  .step_target(step_target),
  .pc         (pc),
  .reg_wr     (reg_wr),
  .reg_rd     (reg_rd),
  .reg_rdata  (reg_rdata),
  .reg_hit    (reg_hit),
  .ovf_err    (ovf_err)
);

// File: tb/test_lr_sequencer.sv
module test_lr_sequencer;
  localparam int PC_W = 12;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            step_en = 1'b0;
  logic [1:0]      step_op = 2'd0;
  logic [1:0]      step_dst = 2'd0;
  logic [1:0]      step_src = 2'd0;
  logic [PC_W-1:0] step_target = '0;
  logic [PC_W-1:0] pc;
  logic [15:0]     reg_addr = 16'h0;
  logic            reg_wr = 1'b0;
  logic            reg_rd = 1'b0;
  logic [PC_W-1:0] reg_wdata = '0;
  logic [PC_W-1:0] reg_rdata;
  logic            reg_hit;
  logic            ovf_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lr_sequencer i_lr_sequencer (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .step_op(step_op),
    .step_dst(step_dst), .step_src(step_src), .step_target(step_target),
    .pc(pc), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_hit(reg_hit),
    .ovf_err(ovf_err)
  );

  task automatic check(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, actual, expected);
    end
  endtask

  task automatic step(input logic [1:0] op, input logic [1:0] dst,
                      input logic [1:0] src, input logic [PC_W-1:0] tgt);
    step_en = 1'b1; step_op = op; step_dst = dst; step_src = src;
    step_target = tgt;
    @(posedge clk); #1;
    step_en = 1'b0;
  endtask

  task automatic idle();
    @(posedge clk); #1;
  endtask

  task automatic port_write(input logic [15:0] a, input logic [PC_W-1:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic port_read(input logic [15:0] a, output logic [PC_W-1:0] d,
                           output logic hit);
    reg_addr = a; reg_rd = 1'b1;
    #1;
    d = reg_rdata; hit = reg_hit;
    @(posedge clk); #1;
    reg_rd = 1'b0;
  endtask

  task automatic t_reset();
    logic [PC_W-1:0] d; logic h;
    check("R1 pc", int'(pc), 0);
    check("R1 ovf", int'(ovf_err), 0);
    for (int i = 0; i < 4; i++) begin
      port_read(16'h0868 + 16'(i), d, h);
      check("R1 link", int'(d), 0);
      check("R6 hit", int'(h), 1);
    end
  endtask

  task automatic t_advance();
    step(2'd0, 0, 0, 0); step(2'd0, 0, 0, 0); step(2'd0, 0, 0, 0);
    check("R2 advance", int'(pc), 3);
    idle(); idle();
    check("R2 hold", int'(pc), 3);
    step(2'd1, 0, 0, 12'hFFF);
    check("R3 jump top", int'(pc), 12'hFFF);
    step(2'd0, 0, 0, 0);
    check("R2 wrap", int'(pc), 0);
  endtask

  task automatic t_call_ret();
    logic [PC_W-1:0] d; logic h;
    step(2'd1, 0, 0, 12'h123);
    check("R3 jump", int'(pc), 12'h123);
    step(2'd2, 2'd1, 0, 12'h200);
    check("R4 call pc", int'(pc), 12'h200);
    port_read(16'h0869, d, h);
    check("R4 call link", int'(d), 12'h124);
    step(2'd3, 2'd2, 2'd1, 12'h000);
    check("R5 ret pc", int'(pc), 12'h124);
    port_read(16'h086A, d, h);
    check("R5 ret link", int'(d), 12'h201);
    step(2'd2, 2'd3, 0, 12'h300);
    step(2'd3, 2'd3, 2'd3, 12'h000);
    check("R5 same index pc", int'(pc), 12'h125);
    port_read(16'h086B, d, h);
    check("R5 same index link", int'(d), 12'h301);
    check("R8 no ovf", int'(ovf_err), 0);
  endtask

  task automatic t_pending();
    logic [PC_W-1:0] d; logic h;
    port_write(16'h0868, 12'h055);
    step(2'd3, 2'd2, 2'd0, 12'h000);
    check("R7 pending not live", int'(pc), 0);
    port_read(16'h0868, d, h);
    check("R7 read returns pending", int'(d), 12'h055);
    step(2'd3, 2'd2, 2'd0, 12'h000);
    check("R7 live after read", int'(pc), 12'h055);
    port_read(16'h0868, d, h);
    check("R7 second read", int'(d), 12'h055);
  endtask

  task automatic t_window();
    logic [PC_W-1:0] d; logic h;
    port_read(16'h0867, d, h);
    check("R9 below window data", int'(d), 0);
    check("R6 below window hit", int'(h), 0);
    port_write(16'h086C, 12'hABC);
    port_read(16'h086B, d, h);
    check("R6 outside write ignored", int'(d), 12'h301);
    port_read(16'h086C, d, h);
    check("R9 above window data", int'(d), 0);
    idle();
    check("R9 idle rdata", int'(reg_rdata), 0);
  endtask

  task automatic t_overflow();
    logic [PC_W-1:0] d; logic h;
    step(2'd2, 2'd0, 0, 12'h400);
    check("R8 first call clean", int'(ovf_err), 0);
    step(2'd2, 2'd0, 0, 12'h410);
    check("R8 reuse flags", int'(ovf_err), 1);
    port_read(16'h0868, d, h);
    check("R8 still overwrites", int'(d), 12'h401);
    step(2'd3, 2'd1, 2'd0, 12'h000);
    check("R5 ret after reuse", int'(pc), 12'h401);
    check("R8 sticky", int'(ovf_err), 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_advance();
    t_call_ret();
    t_pending();
    t_window();
    t_overflow();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule